// File: doc/BRIEF.md
# Burst SRAM Address and Cycle Controller

This block sits in front of a synchronous, pipelined burst memory array and turns the external control pins into one registered access per clock. Two active-low start strobes can open a burst. The processor-side strobe needs chip enable and always reads. The controller-side strobe can read, write or deselect. After a start, an active-low advance input steps a 2-bit burst counter. A static order pin chooses linear or interleaved stepping of the two low address bits. A held advance gives a wait cycle.

Each clock the block presents a registered internal address, a read or write strobe, per-byte write enables and the write data sampled at that edge. It also keeps a registered deselect flag. A sleep input puts the block in standby. Read data from the array comes back through a two-stage output pipeline. The final stage is gated combinationally by an active-low output enable. There is no back-pressure: every accepted cycle finishes in a fixed number of clocks, so all pins are plain levels and no valid/ready handshake is used.

Top module: `sbram_addr_ctrl`

## Requirements
- R1: While reset is asserted, mem_rd, mem_wr and mem_bwe are 0, deselected is 1, dq_drive is 0 and mem_addr is 0.
- R2: A clock edge with proc_start_n low, ce_n low and sleep low loads ext_addr into mem_addr and makes the next cycle a read (mem_rd=1, mem_wr=0, deselected=0), whatever the write inputs are.
- R3: proc_start_n low with ce_n high does not start a cycle. It behaves as if the strobe were high.
- R4: A clock edge with ctrl_start_n low, ce_n low and proc_start_n not effective loads ext_addr. It gives a write when any byte is enabled and a read otherwise. mem_rd and mem_wr are never both 1.
- R5: ctrl_start_n low with ce_n high captures the address and sets deselected. No access happens, and advance has no effect until the next start.
- R6: When both strobes are low and ce_n is low, the processor strobe wins and the cycle is a read.
- R7: With order_sel=0, advance low during an active burst sets the low two address bits to (start + n) mod 4 on the n-th step.
- R8: With order_sel=1, the n-th step sets the low two bits to start XOR (n mod 4).
- R9: Advance high with no start gives a wait: mem_addr is held and mem_rd and mem_wr are 0.
- R10: Address bits 18:2 never change during a burst, and the fourth step returns to the start address.
- R11: Byte enables: wr_all_n low enables both bytes. Otherwise byte_we_n[0] enables byte 0 (data bits 8:0) and byte_we_n[1] enables byte 1 (bits 17:9). mem_bwe[b]=1 marks an enabled byte. On a write, mem_wdata takes the wdata sampled at that edge. It holds otherwise.
- R12: A new effective start during a burst ends it at once and restarts counting from the new address.
- R13: While sleep is high, all strobes and advance are ignored. The edge leaves no access, deselected=1, dq_drive=0, and the burst is ended.
- R14: Array data for a read appears on dq_out two clocks after the edge that issued the read. dq_drive is 1 only for such data while out_en_n is low, and out_en_n acts without a clock. dq_out is 0 when not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Active-high standby |
| ce_n | input | 1 | Active-low chip enable |
| proc_start_n | input | 1 | Processor start strobe, active low |
| ctrl_start_n | input | 1 | Controller start strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | 0 linear, 1 interleaved |
| wr_all_n | input | 1 | Global write, active low |
| byte_we_n | input | 2 | Per-byte write enables, active low |
| ext_addr | input | 19 | External address |
| wdata | input | 18 | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata_arr | input | 18 | Read data from the array for mem_addr |
| mem_addr | output | 19 | Internal array address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_bwe | output | 2 | Per-byte write enables, active high |
| mem_wdata | output | 18 | Registered write data |
| deselected | output | 1 | Registered deselect flag |
| dq_out | output | 18 | Read data output |
| dq_drive | output | 1 | Output drivers enabled |

## Verification
Several functions can land on the same edge: a start strobe during a running burst, both start strobes together, and sleep with strobes and advance all held low. The bench drives each of these pairs deliberately, in both burst orders. It judges each cycle against a behavioural model that applies the stated priority: sleep first, then the processor start, then the controller start, then advance. Toggling the output enable between edges checks that the output gating does not wait for a clock.

// File: rtl/sbram_pkg.sv
package sbram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_DESEL = 2'd3
  } op_e;
endpackage

// File: rtl/sbram_cycle_decode.sv
module sbram_cycle_decode #(
  parameter int NBYTES = 2
) (
  input  logic              sleep,
  input  logic              ce_n,
  input  logic              proc_start_n,
  input  logic              ctrl_start_n,
  input  logic              step_n,
  input  logic              burst_active,
  input  logic              wr_all_n,
  input  logic [NBYTES-1:0] byte_we_n,
  output logic              load,
  output logic              step,
  output sbram_pkg::op_e    op,
  output logic [NBYTES-1:0] bwe
);
  import sbram_pkg::*;

  logic [NBYTES-1:0] req;
  logic              any_wr;

  // each byte is enabled by its own strobe or by the global one
  for (genvar b = 0; b < NBYTES; b++) begin : g_req
    assign req[b] = ~wr_all_n | ~byte_we_n[b];
  end
  assign any_wr = |req;

  always_comb begin
    load = 1'b0;
    step = 1'b0;
    op   = OP_NONE;
    if (sleep) begin
      op = OP_NONE;
    end else if (!proc_start_n && !ce_n) begin
      load = 1'b1;
      op   = OP_READ;
    end else if (!ctrl_start_n) begin
      load = 1'b1;
      if (ce_n)        op = OP_DESEL;
      else if (any_wr) op = OP_WRITE;
      else             op = OP_READ;
    end else if (burst_active && !step_n) begin
      step = 1'b1;
      op   = any_wr ? OP_WRITE : OP_READ;
    end
    bwe = (op == OP_WRITE) ? req : '0;
  end
endmodule

// File: rtl/sbram_burst_seq.sv
module sbram_burst_seq #(
  parameter int ADDR_W  = 19,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic              start_ok,
  input  logic              step,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic              active,
  output logic [ADDR_W-1:0] addr
);
  logic [BURST_W-1:0] base_lo;
  logic [BURST_W-1:0] cnt;
  logic [BURST_W-1:0] cnt_nx;
  logic [BURST_W-1:0] lo_nx;

  assign cnt_nx = cnt + {{(BURST_W-1){1'b0}}, 1'b1};
  assign lo_nx  = order_sel ? (base_lo ^ cnt_nx) : (base_lo + cnt_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      base_lo <= '0;
      cnt     <= '0;
      active  <= 1'b0;
    end else if (flush) begin
      active <= 1'b0;
    end else if (load) begin
      addr    <= ext_addr;
      base_lo <= ext_addr[BURST_W-1:0];
      cnt     <= '0;
      active  <= start_ok;
    end else if (step) begin
      cnt                <= cnt_nx;
      addr[BURST_W-1:0]  <= lo_nx;
    end
  end
endmodule

// File: rtl/sbram_read_pipe.sv
module sbram_read_pipe #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              rd,
  input  logic [DATA_W-1:0] rdata_arr,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive
);
  logic              v1, v2;
  logic [DATA_W-1:0] d1, d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      d1 <= '0;
      d2 <= '0;
    end else begin
      d1 <= rdata_arr;
      d2 <= d1;
      v1 <= rd & ~flush;
      v2 <= v1 & ~flush;
    end
  end

  assign dq_drive = v2 & ~out_en_n;
  assign dq_out   = dq_drive ? d2 : '0;
endmodule

// File: rtl/sbram_addr_ctrl.sv
module sbram_addr_ctrl #(
  parameter int ADDR_W  = 19,
  parameter int BYTE_W  = 9,
  parameter int NBYTES  = 2,
  parameter int BURST_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sleep,
  input  logic                     ce_n,
  input  logic                     proc_start_n,
  input  logic                     ctrl_start_n,
  input  logic                     step_n,
  input  logic                     order_sel,
  input  logic                     wr_all_n,
  input  logic [NBYTES-1:0]        byte_we_n,
  input  logic [ADDR_W-1:0]        ext_addr,
  input  logic [BYTE_W*NBYTES-1:0] wdata,
  input  logic                     out_en_n,
  input  logic [BYTE_W*NBYTES-1:0] rdata_arr,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic                     mem_rd,
  output logic                     mem_wr,
  output logic [NBYTES-1:0]        mem_bwe,
  output logic [BYTE_W*NBYTES-1:0] mem_wdata,
  output logic                     deselected,
  output logic [BYTE_W*NBYTES-1:0] dq_out,
  output logic                     dq_drive
);
  import sbram_pkg::*;

  localparam int DATA_W = BYTE_W * NBYTES;

  logic              load, step, active;
  op_e               op;
  logic [NBYTES-1:0] bwe;

  sbram_cycle_decode #(.NBYTES(NBYTES)) u_dec (
    .sleep        (sleep),
    .ce_n         (ce_n),
    .proc_start_n (proc_start_n),
    .ctrl_start_n (ctrl_start_n),
    .step_n       (step_n),
    .burst_active (active),
    .wr_all_n     (wr_all_n),
    .byte_we_n    (byte_we_n),
    .load         (load),
    .step         (step),
    .op           (op),
    .bwe          (bwe)
  );

  sbram_burst_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (sleep),
    .load      (load),
    .start_ok  (op != OP_DESEL),
    .step      (step),
    .order_sel (order_sel),
    .ext_addr  (ext_addr),
    .active    (active),
    .addr      (mem_addr)
  );

  sbram_read_pipe #(.DATA_W(DATA_W)) u_rp (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (sleep),
    .rd        (mem_rd),
    .rdata_arr (rdata_arr),
    .out_en_n  (out_en_n),
    .dq_out    (dq_out),
    .dq_drive  (dq_drive)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      mem_bwe    <= '0;
      mem_wdata  <= '0;
      deselected <= 1'b1;
    end else if (sleep) begin
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      mem_bwe    <= '0;
      deselected <= 1'b1;
    end else begin
      mem_rd  <= (op == OP_READ);
      mem_wr  <= (op == OP_WRITE);
      mem_bwe <= bwe;
      if (op == OP_WRITE) mem_wdata <= wdata;
      if (load) deselected <= (op == OP_DESEL);
    end
  end
endmodule

// File: rtl/sbram_addr_ctrl_chk.sv
module sbram_addr_ctrl_chk #(
  parameter int ADDR_W  = 19,
  parameter int NBYTES  = 2,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              ce_n,
  input logic              proc_start_n,
  input logic              ctrl_start_n,
  input logic              step_n,
  input logic              wr_all_n,
  input logic              out_en_n,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [NBYTES-1:0] mem_bwe,
  input logic              deselected,
  input logic              dq_drive
);
  // R2
  proc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !proc_start_n && !ce_n) |=>
      (mem_rd && !mem_wr && !deselected && mem_addr == $past(ext_addr)));

  // R4
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && proc_start_n && !ctrl_start_n && !ce_n && !wr_all_n) |=>
      (mem_wr && (&mem_bwe)));

  // R4
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr}));

  // R5
  desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deselected |-> (!mem_rd && !mem_wr));

  // R9
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && proc_start_n && ctrl_start_n && step_n) |=>
      (!mem_rd && !mem_wr && $stable(mem_addr)));

  // R10
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && proc_start_n && ctrl_start_n) |=>
      (mem_addr[ADDR_W-1:BURST_W] == $past(mem_addr[ADDR_W-1:BURST_W])));

  // R13
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!mem_rd && !mem_wr && deselected && !dq_drive));

  // R14
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !sleep) ##1 !sleep |=> (dq_drive == !out_en_n));
endmodule

bind sbram_addr_ctrl sbram_addr_ctrl_chk #(
  .ADDR_W(ADDR_W), .NBYTES(NBYTES), .BURST_W(BURST_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .ce_n(ce_n),
  .proc_start_n(proc_start_n), .ctrl_start_n(ctrl_start_n),
  .step_n(step_n), .wr_all_n(wr_all_n), .out_en_n(out_en_n),
  .ext_addr(ext_addr), .mem_addr(mem_addr), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .mem_bwe(mem_bwe), .deselected(deselected),
  .dq_drive(dq_drive)
);

// File: tb/sbram_addr_ctrl_tb.sv
`timescale 1ns/1ps
module sbram_addr_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep, ce_n, proc_start_n, ctrl_start_n, step_n, order_sel;
  logic        wr_all_n, out_en_n;
  logic [1:0]  byte_we_n;
  logic [18:0] ext_addr;
  logic [17:0] wdata, rdata_arr;
  logic [18:0] mem_addr;
  logic        mem_rd, mem_wr, deselected, dq_drive;
  logic [1:0]  mem_bwe;
  logic [17:0] mem_wdata, dq_out;

  always #4 clk = ~clk;

  sbram_addr_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .ce_n(ce_n),
    .proc_start_n(proc_start_n), .ctrl_start_n(ctrl_start_n),
    .step_n(step_n), .order_sel(order_sel), .wr_all_n(wr_all_n),
    .byte_we_n(byte_we_n), .ext_addr(ext_addr), .wdata(wdata),
    .out_en_n(out_en_n), .rdata_arr(rdata_arr), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_bwe(mem_bwe),
    .mem_wdata(mem_wdata), .deselected(deselected), .dq_out(dq_out),
    .dq_drive(dq_drive)
  );

  function automatic logic [17:0] arr_val(input logic [18:0] a);
    return {a[8:0] ^ 9'h15A, a[18:10]};
  endfunction
  assign rdata_arr = arr_val(mem_addr);

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    run_cmp = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [18:0] e_addr, base;
  logic        e_rd, e_wr, e_des, act, p1v, p2v;
  logic [1:0]  e_bwe;
  logic [17:0] e_wd, p1d, p2d;
  int          n;

  always @(posedge clk) begin
    if (!rst_n) begin
      e_addr = 0; base = 0; e_rd = 0; e_wr = 0; e_des = 1; act = 0;
      p1v = 0; p2v = 0; e_bwe = 0; e_wd = 0; p1d = 0; p2d = 0; n = 0;
    end else begin
      logic r0, r1, anyw;
      int   lo;
      p2v = p1v; p2d = p1d; p1v = e_rd; p1d = arr_val(e_addr);
      r0 = !wr_all_n || !byte_we_n[0];
      r1 = !wr_all_n || !byte_we_n[1];
      anyw = r0 || r1;
      if (sleep) begin
        e_rd = 0; e_wr = 0; e_bwe = 0; e_des = 1; act = 0; p1v = 0; p2v = 0;
      end else if (!proc_start_n && !ce_n) begin
        base = ext_addr; n = 0; act = 1; e_addr = ext_addr;
        e_rd = 1; e_wr = 0; e_bwe = 0; e_des = 0;
      end else if (!ctrl_start_n) begin
        base = ext_addr; n = 0; e_addr = ext_addr;
        if (ce_n) begin
          act = 0; e_des = 1; e_rd = 0; e_wr = 0; e_bwe = 0;
        end else begin
          act = 1; e_des = 0; e_rd = !anyw; e_wr = anyw;
          e_bwe = anyw ? {r1, r0} : 2'b00;
          if (anyw) e_wd = wdata;
        end
      end else if (act && !step_n) begin
        n = n + 1;
        lo = order_sel ? (int'(base[1:0]) ^ (n % 4)) : ((int'(base[1:0]) + n) % 4);
        e_addr = {base[18:2], 2'(lo)};
        e_rd = !anyw; e_wr = anyw; e_bwe = anyw ? {r1, r0} : 2'b00;
        if (anyw) e_wd = wdata;
      end else begin
        e_rd = 0; e_wr = 0; e_bwe = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      logic        xd;
      logic [17:0] xq;
      xd = p2v && !out_en_n;
      xq = xd ? p2d : 18'h0;
      check(cur_req,
            {3'b0, mem_addr, mem_rd, mem_wr, mem_bwe, mem_wdata, deselected, dq_out, dq_drive},
            {3'b0, e_addr, e_rd, e_wr, e_bwe, e_wd, e_des, xq, xd});
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask
  task automatic quiet();
    sleep = 0; ce_n = 0; proc_start_n = 1; ctrl_start_n = 1; step_n = 1;
    wr_all_n = 1; byte_we_n = 2'b11;
  endtask
  task automatic pstart(input logic [18:0] a);
    quiet(); proc_start_n = 0; ext_addr = a; tick();
  endtask
  task automatic cstart(input logic [18:0] a, input logic cen, input logic [1:0] bw, input logic ga);
    quiet(); ctrl_start_n = 0; ce_n = cen; ext_addr = a; byte_we_n = bw; wr_all_n = ga; tick();
  endtask
  task automatic adv(input int k);
    for (int i = 0; i < k; i++) begin quiet(); step_n = 0; tick(); end
  endtask
  task automatic hold(input int k);
    for (int i = 0; i < k; i++) begin quiet(); tick(); end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    quiet(); order_sel = 0; out_en_n = 0; ext_addr = 0; wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", {40'b0, mem_rd, mem_wr, mem_bwe, deselected, dq_drive, mem_addr}, {40'b0, 6'b000010, 19'h0});
    @(posedge clk); #2; rst_n = 1; run_cmp = 1;

    cur_req = "R2"; wr_all_n = 0;
    pstart(19'h1_2345);
    cur_req = "R7"; adv(3);
    cur_req = "R10"; adv(2);
    cur_req = "R14"; hold(1); out_en_n = 1; hold(1); out_en_n = 0; hold(2);

    cur_req = "R8"; order_sel = 1;
    pstart(19'h2_AB56);
    adv(1);
    cur_req = "R9"; hold(2);
    cur_req = "R8"; adv(4);
    cur_req = "R3"; quiet(); ce_n = 1; proc_start_n = 0; ext_addr = 19'h7_0000; tick();
    adv(1);

    cur_req = "R4"; order_sel = 0;
    cstart(19'h0_4443, 0, 2'b10, 1);
    quiet(); step_n = 0; byte_we_n = 2'b01; wdata = 18'h2_5A5A; tick();
    adv(1);
    cstart(19'h0_5550, 0, 2'b11, 1);
    cur_req = "R11"; wdata = 18'h3_C3C3;
    cstart(19'h1_1111, 0, 2'b11, 0);
    wdata = 18'h1_0F0F; cstart(19'h1_1112, 0, 2'b01, 1);

    cur_req = "R5"; cstart(19'h6_6666, 1, 2'b11, 1);
    adv(3); hold(1);

    cur_req = "R6"; quiet(); proc_start_n = 0; ctrl_start_n = 0; wr_all_n = 0;
    ext_addr = 19'h3_3331; tick();
    adv(1);
    cur_req = "R12"; pstart(19'h4_0002); adv(1);
    cstart(19'h4_1003, 0, 2'b11, 1); adv(2);
    order_sel = 1; pstart(19'h4_2001); adv(1);
    quiet(); step_n = 0; proc_start_n = 0; ext_addr = 19'h4_3002; tick(); adv(2);

    cur_req = "R13"; pstart(19'h5_0001);
    quiet(); sleep = 1; proc_start_n = 0; ctrl_start_n = 0; step_n = 0; tick();
    quiet(); sleep = 1; tick();
    adv(2); hold(2);
    pstart(19'h5_1113); adv(2); hold(3);

    run_cmp = 0;
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule